// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel running in waveform mode. A single up-counter is shared by two pulse outputs, A and B. The counter advances on a count-clock enable. That enable comes from one of four binary prescalings of the master clock, or from a synchronised slow reference clock. The counter returns to zero after it reaches the period register, so both outputs always share the same period.

Each output has its own compare register and three 2-bit action fields. The fields say what the output does on a match with its own compare register, on a match with the period register, and on a software trigger. A PWM waveform comes from pairing "clear on own compare" with "set on period match" (inverted polarity swaps the two). A 0 % or 100 % level comes from leaving both compare actions at none and parking the output with a software trigger. The clock can then be stopped and the parked level stays on the pin.

Software reaches the channel through a plain single-cycle register write port and a combinational read port.

Top module: `wave_timer_chan`

## Requirements
- R1: The MODE clock-select field (bits 2:0) picks the count enable. Values 0, 1, 2 and 3 give a one-cycle pulse whenever the low 1, 3, 5 or 7 bits of a free-running 7-bit prescale counter are all ones; that counter is cleared by reset and counts every master clock. Values 4 to 7 give one pulse for each rising edge of the slow clock, taken after two synchronising flops.
- R2: While the clock is enabled, each count enable adds one to the counter. When the counter equals the period register (address 4) at a count enable, it goes to zero instead.
- R3: An action code is 0 none, 1 set, 2 clear or 3 toggle, where toggle inverts the current level. In MODE, output A has its own-compare action at bits 4:3, its period action at 6:5 and its software-trigger action at 8:7. Output B uses bits 10:9, 12:11 and 14:13 for the same three fields.
- R4: A count enable with the counter equal to output A's compare register (address 2) applies A's own-compare action. Output B does the same with address 3. A count enable with the counter equal to the period register applies each output's period action.
- R5: If one count enable matches both an output's own compare register and the period register, only the period action is applied to that output.
- R6: A write to the command register (address 0) is decoded bit by bit. Bit 0 enables the clock and bit 1 disables it; disable wins if both are set. Bit 2 is a software trigger: at that same edge the counter becomes zero and each output takes its software-trigger action. The trigger overrides any count event in that cycle.
- R7: When both compare actions of an output are none, the output keeps its last software-trigger level. While the clock is disabled the counter and the outputs do not change.
- R8: After reset the counter is 0, both outputs are low, the clock is disabled and MODE and all compare registers are 0.
- R9: Register writes take effect from the next master clock cycle. Reads return MODE at address 1, the compare registers at 2 to 4, the live counter at 5, and 0 at every other address.
- R10: With A set to clear on own compare and set on period, A is high for A+1 of every period+1 count enables. With B set to the opposite actions, B is the inverse of that waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow reference clock, asynchronous |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
Every result appears at the master clock edge that samples its cause. A command or count enable at edge N shows its new counter value and output levels from edge N on. A register write at edge N is first used for matching at edge N+1. Read data is valid in the same cycle as the address.

A reference model in the bench follows these rules. At each rising edge it pushes the expected levels and counter value into a queue, and a monitor pops them half a cycle later at the falling edge. Directed reads are made a few nanoseconds after a rising edge and never at the monitor's sampling point. The slow-clock case is checked as a count window that allows one edge of synchronisation uncertainty.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_t;

  typedef struct packed {
    act_t       b_sw;
    act_t       b_per;
    act_t       b_cmp;
    act_t       a_sw;
    act_t       a_per;
    act_t       a_cmp;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] ADR_CMD  = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd1;
  localparam logic [2:0] ADR_CMPA = 3'd2;
  localparam logic [2:0] ADR_CMPB = 3'd3;
  localparam logic [2:0] ADR_PER  = 3'd4;
  localparam logic [2:0] ADR_CNT  = 3'd5;

  function automatic logic act_apply(input act_t a, input logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int STAGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int PRE_W = 2 * STAGES - 1;

  logic [PRE_W-1:0] pre_q;
  logic [2:0]       slow_sync_q;
  logic [STAGES-1:0] stage_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q       <= '0;
      slow_sync_q <= '0;
    end else begin
      pre_q       <= pre_q + PRE_W'(1);
      slow_sync_q <= {slow_sync_q[1:0], slow_clk};
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign stage_hit[s] = &pre_q[2*s:0];
  end

  always_comb begin
    if (int'(sel) < STAGES) tick = stage_hit[sel[1:0]];
    else                    tick = slow_sync_q[1] & ~slow_sync_q[2];
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !restart && wrap |=> cnt == '0);
  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !restart && !wrap |=> cnt == $past(cnt) + CNT_W'(1));
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !restart |=> $stable(cnt));

endmodule

// File: rtl/wt_out_unit.sv
module wt_out_unit
  import wt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sw,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  act_t             act_cmp,
  input  act_t             act_per,
  input  act_t             act_sw,
  output logic             out_q
);
  logic hit_own;
  logic nxt;

  assign hit_own = (cnt == cmp);

  always_comb begin
    nxt = out_q;
    if (sw)                 nxt = act_apply(act_sw, out_q);
    else if (step && wrap)  nxt = act_apply(act_per, out_q);
    else if (step && hit_own) nxt = act_apply(act_cmp, out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= nxt;
  end

  assert_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw && act_sw == ACT_SET |=> out_q);
  assert_sw_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw && act_sw == ACT_CLR |=> !out_q);
  assert_per_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && !sw && wrap && hit_own && act_per == ACT_SET |=> out_q);
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !sw && !wrap && hit_own && act_cmp == ACT_TGL |=> out_q != $past(out_q));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw && !step |=> $stable(out_q));

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              out_a,
  output logic              out_b
);
  localparam int NOUT = 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_q [NOUT];
  logic [CNT_W-1:0] per_q;
  logic             clk_on_q;
  logic [2:0]       cmd;
  logic             tick, step, wrap;
  logic [CNT_W-1:0] cnt;
  act_t             a_cmp [NOUT];
  act_t             a_per [NOUT];
  act_t             a_sw  [NOUT];
  logic [NOUT-1:0]  outs;

  assign cmd  = (wr_en && wr_addr == ADDR_W'(ADR_CMD)) ? wr_data[2:0] : 3'b000;
  assign step = clk_on_q & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
      per_q    <= '0;
      clk_on_q <= 1'b0;
    end else begin
      if (cmd[1])      clk_on_q <= 1'b0;
      else if (cmd[0]) clk_on_q <= 1'b1;
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(ADR_MODE): mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
          ADDR_W'(ADR_CMPA): cmp_q[0] <= wr_data;
          ADDR_W'(ADR_CMPB): cmp_q[1] <= wr_data;
          ADDR_W'(ADR_PER):  per_q    <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(ADR_MODE): rd_data = CNT_W'(mode_q);
      ADDR_W'(ADR_CMPA): rd_data = cmp_q[0];
      ADDR_W'(ADR_CMPB): rd_data = cmp_q[1];
      ADDR_W'(ADR_PER):  rd_data = per_q;
      ADDR_W'(ADR_CNT):  rd_data = cnt;
      default:           rd_data = '0;
    endcase
  end

  assign a_cmp[0] = mode_q.a_cmp;
  assign a_per[0] = mode_q.a_per;
  assign a_sw[0]  = mode_q.a_sw;
  assign a_cmp[1] = mode_q.b_cmp;
  assign a_per[1] = mode_q.b_per;
  assign a_sw[1]  = mode_q.b_sw;

  wt_prescale #(.STAGES(4)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .sel(mode_q.clk_sel), .tick(tick)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(cmd[2]),
    .period(per_q), .cnt(cnt), .wrap(wrap)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    wt_out_unit #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .step(step), .sw(cmd[2]), .wrap(wrap),
      .cnt(cnt), .cmp(cmp_q[g]), .act_cmp(a_cmp[g]), .act_per(a_per[g]),
      .act_sw(a_sw[g]), .out_q(outs[g])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];

  assert_disable_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[1] |=> !clk_on_q);
  assert_write_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == ADDR_W'(ADR_PER) |=> per_q == $past(wr_data));

endmodule

// File: tb/test_wave_timer_chan.sv
module test_wave_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd5;
  logic [15:0] rd_data;
  logic        out_a, out_b;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    model_on = 1'b0;
  string phase = "R8";

  logic [17:0] exp_q [$];

  wave_timer_chan #(.CNT_W(16), .ADDR_W(3)) i_wave_timer_chan (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_a(out_a), .out_b(out_b)
  );

  always #5 clk = ~clk;
  always #200 slow_clk = ~slow_clk;

  // Reference model built from the requirements
  logic [6:0]  m_pre;
  logic [15:0] m_mode, m_ca, m_cb, m_per, m_cnt;
  logic        m_en, m_oa, m_ob;

  function automatic logic act(input logic [1:0] a, input logic cur);
    case (a)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = '0; m_mode = '0; m_ca = '0; m_cb = '0; m_per = '0;
      m_cnt = '0; m_en = 1'b0; m_oa = 1'b0; m_ob = 1'b0;
    end else begin
      logic [2:0] cmd;
      logic [6:0] mask;
      logic       tk, mc;
      cmd  = (wr_en && wr_addr == 3'd0) ? wr_data[2:0] : 3'b000;
      mask = 7'((1 << (2 * m_mode[1:0] + 1)) - 1);
      tk   = (m_mode[2:0] < 3'd4) ? ((m_pre & mask) == mask) : 1'b0;
      if (cmd[2]) begin
        m_cnt = '0;
        m_oa  = act(m_mode[8:7], m_oa);
        m_ob  = act(m_mode[14:13], m_ob);
      end else if (m_en && tk) begin
        mc = (m_cnt == m_per);
        if (mc) begin
          m_oa = act(m_mode[6:5], m_oa);
          m_ob = act(m_mode[12:11], m_ob);
        end else begin
          if (m_cnt == m_ca) m_oa = act(m_mode[4:3], m_oa);
          if (m_cnt == m_cb) m_ob = act(m_mode[10:9], m_ob);
        end
        m_cnt = mc ? 16'd0 : m_cnt + 16'd1;
      end
      if (cmd[1])      m_en = 1'b0;
      else if (cmd[0]) m_en = 1'b1;
      if (wr_en) begin
        case (wr_addr)
          3'd1: m_mode = {1'b0, wr_data[14:0]};
          3'd2: m_ca   = wr_data;
          3'd3: m_cb   = wr_data;
          3'd4: m_per  = wr_data;
          default: ;
        endcase
      end
      m_pre = m_pre + 7'd1;
      if (model_on) exp_q.push_back({m_oa, m_ob, m_cnt});
    end
  end

  task automatic chk(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // Monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [17:0] e;
      e = exp_q.pop_front();
      chk({phase, " out_a"}, {15'd0, out_a}, {15'd0, e[17]});
      chk({phase, " out_b"}, {15'd0, out_b}, {15'd0, e[16]});
      if (rd_addr == 3'd5) chk({phase, " count"}, rd_data, e[15:0]);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(posedge clk);
    #2 rd_addr = a;
    #1 v = rd_data;
    #1 rd_addr = 3'd5;
  endtask

  function automatic logic [15:0] mk(input int sel, input int acmp, input int aper,
                                     input int asw, input int bcmp, input int bper,
                                     input int bsw);
    return {1'b0, 2'(bsw), 2'(bper), 2'(bcmp), 2'(asw), 2'(aper), 2'(acmp), 3'(sel)};
  endfunction

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 reset state
    rd(3'd5, v); chk("R8 count", v, 16'd0);
    rd(3'd1, v); chk("R8 mode", v, 16'd0);
    rd(3'd4, v); chk("R8 period", v, 16'd0);
    chk("R8 out_a", {15'd0, out_a}, 16'd0);
    chk("R8 out_b", {15'd0, out_b}, 16'd0);
    model_on = 1'b1;

    // R9 readback and address map
    phase = "R9";
    wr(3'd2, 16'd3); wr(3'd3, 16'd6); wr(3'd4, 16'd9);
    wr(3'd1, mk(0, 2, 1, 1, 1, 2, 2));
    rd(3'd2, v); chk("R9 cmp A", v, 16'd3);
    rd(3'd3, v); chk("R9 cmp B", v, 16'd6);
    rd(3'd4, v); chk("R9 period", v, 16'd9);
    rd(3'd1, v); chk("R9 mode", v, mk(0, 2, 1, 1, 1, 2, 2));
    rd(3'd7, v); chk("R9 unmapped", v, 16'd0);

    // R10 R4 R2: normal PWM on A, inverted on B, divide by 2
    phase = "R10 R4 R2 pwm";
    wr(3'd0, 16'h5);
    run(120);

    // R5: own compare equals period, period action wins; R3 toggle; R1 divide 8
    phase = "R5 R3 R1 priority";
    wr(3'd2, 16'd9);
    wr(3'd1, mk(1, 2, 1, 1, 3, 3, 0));
    run(300);

    // R7: park outputs and stop clock
    phase = "R7 park";
    wr(3'd1, mk(0, 0, 0, 1, 0, 0, 2));
    wr(3'd0, 16'h6);
    run(40);
    chk("R7 parked out_a", {15'd0, out_a}, 16'd1);
    chk("R7 parked out_b", {15'd0, out_b}, 16'd0);
    rd(3'd5, v); chk("R7 frozen count", v, 16'd0);
    wr(3'd0, 16'h1);
    run(60);
    chk("R7 held out_a", {15'd0, out_a}, 16'd1);

    // R6: software trigger mid-count, and disable beats enable
    phase = "R6 trigger";
    wr(3'd1, mk(0, 2, 1, 2, 1, 2, 1));
    run(7);
    wr(3'd0, 16'h4);
    chk("R6 restart out_a", {15'd0, out_a}, 16'd0);
    run(30);
    wr(3'd0, 16'h3);
    run(20);

    // R1: divide by 32 and 128
    phase = "R1 div32";
    wr(3'd4, 16'd3); wr(3'd2, 16'd1); wr(3'd3, 16'd2);
    wr(3'd1, mk(2, 2, 1, 1, 1, 2, 0));
    wr(3'd0, 16'h5);
    run(400);
    phase = "R1 div128";
    wr(3'd1, mk(3, 2, 1, 1, 1, 2, 0));
    run(1200);

    // R1: slow clock source, counted over a window
    model_on = 1'b0;
    repeat (3) @(posedge clk);
    exp_q.delete();
    wr(3'd4, 16'hFFFF);
    wr(3'd1, mk(4, 0, 0, 0, 0, 0, 0));
    wr(3'd0, 16'h5);
    run(400);
    rd(3'd5, v);
    n_chk++;
    if (v < 16'd9 || v > 16'd11) begin
      n_bad++;
      $display("FAIL R1 slow count: actual %0d expected 9..11", v);
    end

    finish_run();
  end
endmodule